// File: doc/BRIEF.md
# Per-ID In-Flight Transaction Tracker

This block keeps count of the outstanding transactions of one direction (write or read) of an AXI demultiplexer, grouped by a reduced ID. The reduced ID is formed by the caller from the low `LOOK_BITS` bits of the full AXI ID. The block therefore holds `2**LOOK_BITS` slots. Each slot has an in-flight counter and a register naming the master port that its transactions were routed to.

The demultiplexer presents the ID of a new address beat on the lookup port. It receives, in the same cycle, the port that the slot last routed to, whether the slot has anything in flight, and whether the slot is full. The demultiplexer must hold off a new transaction in two cases: when the slot is busy and its stored port differs from the requested port, or when the slot is full.

The block has three increment and decrement requests. Each is a single-cycle strobe carrying an ID, and none of them is ever back-pressured.
- The demultiplexer raises the push strobe when it accepts an address beat.
- It raises the pop strobe on each accepted write response, or on each accepted read beat that carries the last flag.
- On the read side it raises the inject strobe when an atomic write will also return read data.

Top module: `idtrk_top`

## Requirements
- R1: While the active-low asynchronous reset is low, every counter and every stored port index is zero. Lookup of any ID then gives port 0, busy 0 and full 0.
- R2: The lookup outputs are combinational in `lkp_id_i`. `lkp_port_o` is the stored port index of that slot, and `lkp_busy_o` is 1 exactly when that slot's counter is nonzero. Both follow a change of `lkp_id_i` without a clock edge.
- R3: A push raises the pushed slot's counter by one and writes `push_port_i` into that slot's port register. Both changes are visible from the next rising clock edge. A stored port is kept after the counter returns to zero.
- R4: A pop lowers the popped slot's counter by one at the next rising edge. The caller never pops a slot whose counter is zero unless the same slot is pushed or injected in the same cycle.
- R5: An inject raises the injected slot's counter by one and leaves that slot's port register unchanged.
- R6: When several requests hit the same slot in one cycle, each increment and each decrement counts once:
  - push with pop leaves the counter unchanged;
  - inject with pop leaves the counter unchanged;
  - push with inject adds two;
  - all three add one.
- R7: A counter can hold `MAX_TRANS`. `full_o` is 1 exactly when the looked-up slot's counter equals `MAX_TRANS`. The caller never pushes a full slot unless the same slot is popped in that cycle.
- R8: A request changes only the slot it names. The counters and port registers of all other slots are left unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| lkp_id_i | input | LOOK_BITS | Reduced ID to look up |
| lkp_port_o | output | PORT_W | Stored master port index of the looked-up slot |
| lkp_busy_o | output | 1 | Looked-up slot has transactions in flight |
| full_o | output | 1 | Looked-up slot's counter is at MAX_TRANS |
| push_i | input | 1 | Push strobe, one per accepted address beat |
| push_id_i | input | LOOK_BITS | Reduced ID of the push |
| push_port_i | input | PORT_W | Master port index the pushed transaction goes to |
| pop_i | input | 1 | Pop strobe, one per completed transaction |
| pop_id_i | input | LOOK_BITS | Reduced ID of the pop |
| inj_i | input | 1 | Inject strobe (atomic write returning read data) |
| inj_id_i | input | LOOK_BITS | Reduced ID of the inject |

## Verification
The bench builds the block with `LOOK_BITS = 2`, `MAX_TRANS = 3` and `PORT_W = 2`. These values give four slots and every port value. They also bring a slot to full after three pushes, so the full flag and the saturation edge of the counter come into reach within a few cycles. With this small slot count, same-cycle collisions of push, pop and inject on one slot are easy to arrange. The count also makes it easy to confirm that neighbouring slots stay untouched during those collisions.

// File: rtl/idtrk_pkg.sv
package idtrk_pkg;

  function automatic int unsigned cnt_bits(input int unsigned max_trans);
    return $clog2(max_trans + 1);
  endfunction

  function automatic int unsigned slot_count(input int unsigned look_bits);
    return 1 << look_bits;
  endfunction

endpackage

// File: rtl/idtrk_onehot.sv
module idtrk_onehot #(
  parameter int unsigned SEL_W = 3,
  localparam int unsigned N = 1 << SEL_W
) (
  input  logic             en_i,
  input  logic [SEL_W-1:0] sel_i,
  output logic [N-1:0]     hot_o
);
  for (genvar i = 0; i < N; i++) begin : g_bit
    assign hot_o[i] = en_i && (sel_i == SEL_W'(i));
  end
endmodule

// File: rtl/idtrk_slot.sv
module idtrk_slot #(
  parameter int unsigned CNT_W     = 4,
  parameter int unsigned PORT_W    = 3,
  parameter int unsigned MAX_TRANS = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              push_hit_i,
  input  logic              inj_hit_i,
  input  logic              pop_hit_i,
  input  logic [PORT_W-1:0] wr_port_i,
  output logic [CNT_W-1:0]  cnt_o,
  output logic [PORT_W-1:0] port_o
);
  localparam int unsigned SUM_W = CNT_W + 2;

  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [PORT_W-1:0] port_q;
  logic [SUM_W-1:0]  sum;

  always_comb begin
    sum = SUM_W'(cnt_q) + SUM_W'(push_hit_i) + SUM_W'(inj_hit_i);
    if (pop_hit_i && (sum != '0)) sum = sum - SUM_W'(1);
    if (sum > SUM_W'(MAX_TRANS)) sum = SUM_W'(MAX_TRANS);
    cnt_d = sum[CNT_W-1:0];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      port_q <= '0;
    end else begin
      cnt_q <= cnt_d;
      if (push_hit_i) port_q <= wr_port_i;
    end
  end

  assign cnt_o  = cnt_q;
  assign port_o = port_q;
endmodule

// File: rtl/idtrk_lookup.sv
module idtrk_lookup #(
  parameter int unsigned LOOK_BITS = 3,
  parameter int unsigned CNT_W     = 4,
  parameter int unsigned PORT_W    = 3,
  parameter int unsigned MAX_TRANS = 8,
  localparam int unsigned SLOTS = 1 << LOOK_BITS
) (
  input  logic [LOOK_BITS-1:0]          id_i,
  input  logic [SLOTS-1:0][CNT_W-1:0]   cnt_all_i,
  input  logic [SLOTS-1:0][PORT_W-1:0]  port_all_i,
  output logic [PORT_W-1:0]             port_o,
  output logic                          busy_o,
  output logic                          full_o
);
  logic [CNT_W-1:0] sel_cnt;

  assign sel_cnt = cnt_all_i[id_i];
  assign port_o  = port_all_i[id_i];
  assign busy_o  = |sel_cnt;
  assign full_o  = (sel_cnt == CNT_W'(MAX_TRANS));
endmodule

// File: rtl/idtrk_top.sv
module idtrk_top #(
  parameter int unsigned LOOK_BITS = 3,
  parameter int unsigned MAX_TRANS = 8,
  parameter int unsigned PORT_W    = 3
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [LOOK_BITS-1:0] lkp_id_i,
  output logic [PORT_W-1:0]    lkp_port_o,
  output logic                 lkp_busy_o,
  output logic                 full_o,
  input  logic                 push_i,
  input  logic [LOOK_BITS-1:0] push_id_i,
  input  logic [PORT_W-1:0]    push_port_i,
  input  logic                 pop_i,
  input  logic [LOOK_BITS-1:0] pop_id_i,
  input  logic                 inj_i,
  input  logic [LOOK_BITS-1:0] inj_id_i
);
  localparam int unsigned SLOTS = idtrk_pkg::slot_count(LOOK_BITS);
  localparam int unsigned CNT_W = idtrk_pkg::cnt_bits(MAX_TRANS);

  logic [SLOTS-1:0]             push_hot, pop_hot, inj_hot;
  logic [SLOTS-1:0][CNT_W-1:0]  cnt_q;
  logic [SLOTS-1:0][PORT_W-1:0] port_q;

  idtrk_onehot #(.SEL_W(LOOK_BITS)) u_dec_push (
    .en_i(push_i), .sel_i(push_id_i), .hot_o(push_hot));
  idtrk_onehot #(.SEL_W(LOOK_BITS)) u_dec_pop (
    .en_i(pop_i), .sel_i(pop_id_i), .hot_o(pop_hot));
  idtrk_onehot #(.SEL_W(LOOK_BITS)) u_dec_inj (
    .en_i(inj_i), .sel_i(inj_id_i), .hot_o(inj_hot));

  for (genvar s = 0; s < SLOTS; s++) begin : g_slot
    idtrk_slot #(
      .CNT_W(CNT_W), .PORT_W(PORT_W), .MAX_TRANS(MAX_TRANS)
    ) u_slot (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .push_hit_i (push_hot[s]),
      .inj_hit_i  (inj_hot[s]),
      .pop_hit_i  (pop_hot[s]),
      .wr_port_i  (push_port_i),
      .cnt_o      (cnt_q[s]),
      .port_o     (port_q[s])
    );
  end

  idtrk_lookup #(
    .LOOK_BITS(LOOK_BITS), .CNT_W(CNT_W), .PORT_W(PORT_W), .MAX_TRANS(MAX_TRANS)
  ) u_lookup (
    .id_i       (lkp_id_i),
    .cnt_all_i  (cnt_q),
    .port_all_i (port_q),
    .port_o     (lkp_port_o),
    .busy_o     (lkp_busy_o),
    .full_o     (full_o)
  );
endmodule

// File: rtl/idtrk_checker.sv
module idtrk_checker #(
  parameter int unsigned LOOK_BITS = 3,
  parameter int unsigned MAX_TRANS = 8,
  parameter int unsigned PORT_W    = 3,
  parameter int unsigned CNT_W     = 4,
  localparam int unsigned SLOTS = 1 << LOOK_BITS
) (
  input logic                         clk_i,
  input logic                         rst_ni,
  input logic                         lkp_busy_o,
  input logic                         full_o,
  input logic                         push_i,
  input logic [LOOK_BITS-1:0]         push_id_i,
  input logic [PORT_W-1:0]            push_port_i,
  input logic                         pop_i,
  input logic [LOOK_BITS-1:0]         pop_id_i,
  input logic                         inj_i,
  input logic [LOOK_BITS-1:0]         inj_id_i,
  input logic [SLOTS-1:0][CNT_W-1:0]  cnt_q,
  input logic [SLOTS-1:0][PORT_W-1:0] port_q
);
  logic pop_on_push, inj_on_push, push_on_pop, inj_on_pop;
  assign pop_on_push = pop_i && (pop_id_i == push_id_i);
  assign inj_on_push = inj_i && (inj_id_i == push_id_i);
  assign push_on_pop = push_i && (push_id_i == pop_id_i);
  assign inj_on_pop  = inj_i && (inj_id_i == pop_id_i);

  // R7: a full slot reported on lookup is always also busy
  assert_full_busy_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    full_o |-> lkp_busy_o);

  // R7: caller protocol, no push into a full slot without a same-slot pop
  assert_no_overflow_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_i && !pop_on_push) |-> (cnt_q[push_id_i] < CNT_W'(MAX_TRANS)));

  // R4: caller protocol, no pop of an empty slot
  assert_no_underflow_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pop_i && !push_on_pop && !inj_on_pop) |-> (cnt_q[pop_id_i] != '0));

  // R3: a lone push on a slot adds exactly one
  assert_push_incr_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_i && !pop_on_push && !inj_on_push) |=>
      (cnt_q[$past(push_id_i)] == $past(cnt_q[push_id_i]) + CNT_W'(1)));

  // R3: the pushed port index is stored in the pushed slot
  assert_push_port_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_i |=> (port_q[$past(push_id_i)] == $past(push_port_i)));

  // R4: a lone pop on a slot removes exactly one
  assert_pop_decr_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pop_i && !push_on_pop && !inj_on_pop) |=>
      (cnt_q[$past(pop_id_i)] == $past(cnt_q[pop_id_i]) - CNT_W'(1)));
endmodule

bind idtrk_top idtrk_checker #(
  .LOOK_BITS(LOOK_BITS), .MAX_TRANS(MAX_TRANS), .PORT_W(PORT_W), .CNT_W(CNT_W)
) u_idtrk_checker (
  .clk_i(clk_i), .rst_ni(rst_ni), .lkp_busy_o(lkp_busy_o), .full_o(full_o),
  .push_i(push_i), .push_id_i(push_id_i), .push_port_i(push_port_i),
  .pop_i(pop_i), .pop_id_i(pop_id_i), .inj_i(inj_i), .inj_id_i(inj_id_i),
  .cnt_q(cnt_q), .port_q(port_q)
);

// File: tb/idtrk_top_tb_top.sv
`timescale 1ns/1ps
module idtrk_top_tb_top;
  localparam int unsigned LB = 2;
  localparam int unsigned MT = 3;
  localparam int unsigned PW = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [LB-1:0] lkp_id = '0, push_id = '0, pop_id = '0, inj_id = '0;
  logic [PW-1:0] push_port = '0, lkp_port;
  logic push = 1'b0, pop = 1'b0, inj = 1'b0;
  logic busy, full;

  int checks = 0;
  int fails = 0;

  always #10 clk = ~clk;

  idtrk_top #(.LOOK_BITS(LB), .MAX_TRANS(MT), .PORT_W(PW)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .lkp_id_i(lkp_id), .lkp_port_o(lkp_port),
    .lkp_busy_o(busy), .full_o(full), .push_i(push), .push_id_i(push_id),
    .push_port_i(push_port), .pop_i(pop), .pop_id_i(pop_id),
    .inj_i(inj), .inj_id_i(inj_id));

  typedef struct packed {
    logic          push;
    logic [LB-1:0] pid;
    logic [PW-1:0] pport;
    logic          pop;
    logic [LB-1:0] oid;
    logic          inj;
    logic [LB-1:0] iid;
    logic [LB-1:0] lid;
    logic [PW-1:0] eport;
    logic          ebusy;
    logic          efull;
    logic [7:0]    req;
  } vec_t;

  localparam int NV = 16;
  localparam vec_t VECS [NV] = '{
    '{1, 1, 2, 0, 0, 0, 0, 1, 2, 1, 0, 3}, // R3 push slot1 port2 -> 1
    '{1, 1, 2, 0, 0, 0, 0, 1, 2, 1, 0, 3}, // R3 -> 2
    '{1, 1, 2, 0, 0, 0, 0, 1, 2, 1, 1, 7}, // R7 -> 3 = MAX, full
    '{0, 0, 0, 0, 0, 0, 0, 2, 0, 0, 0, 8}, // R8 slot2 untouched
    '{0, 0, 0, 1, 1, 0, 0, 1, 2, 1, 0, 4}, // R4 pop slot1 -> 2
    '{1, 2, 3, 0, 0, 1, 2, 2, 3, 1, 0, 6}, // R6 push+inj slot2 -> 2
    '{1, 2, 1, 1, 2, 0, 0, 2, 1, 1, 0, 6}, // R6 push+pop -> 2, port1
    '{0, 0, 0, 1, 2, 1, 2, 2, 1, 1, 0, 6}, // R6 inj+pop -> 2
    '{0, 0, 0, 0, 0, 1, 3, 3, 0, 1, 0, 5}, // R5 inj slot3 -> 1, port kept 0
    '{1, 2, 1, 1, 2, 1, 2, 2, 1, 1, 1, 6}, // R6 all three -> 3 full
    '{0, 0, 0, 1, 1, 0, 0, 1, 2, 1, 0, 4}, // R4 slot1 -> 1
    '{0, 0, 0, 1, 1, 0, 0, 1, 2, 0, 0, 4}, // R4 slot1 -> 0, port kept
    '{0, 0, 0, 1, 3, 0, 0, 3, 0, 0, 0, 5}, // R5 slot3 pop -> 0
    '{0, 0, 0, 1, 2, 0, 0, 0, 0, 0, 0, 8}, // R8 slot0 untouched, slot2 -> 2
    '{0, 0, 0, 1, 2, 0, 0, 2, 1, 1, 0, 7}, // R7 slot2 -> 1, not full
    '{0, 0, 0, 1, 2, 0, 0, 2, 1, 0, 0, 4}  // R4 slot2 -> 0
  };

  task automatic check(input string tag, input logic [PW-1:0] ep,
                       input logic eb, input logic ef);
    checks++;
    if (lkp_port !== ep || busy !== eb || full !== ef) begin
      fails++;
      $display("FAIL %s: port/busy/full got %0d/%0d/%0d expected %0d/%0d/%0d",
               tag, lkp_port, busy, full, ep, eb, ef);
    end
  endtask

  task automatic drive_idle();
    push = 1'b0; pop = 1'b0; inj = 1'b0;
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
  endtask

  initial begin
    #5;
    for (int i = 0; i < 4; i++) begin
      lkp_id = LB'(i); #1;
      check("R1 reset lookup", '0, 1'b0, 1'b0);
    end
    @(negedge clk); rst_n = 1'b1;

    for (int v = 0; v < NV; v++) begin
      @(negedge clk);
      push = VECS[v].push; push_id = VECS[v].pid; push_port = VECS[v].pport;
      pop = VECS[v].pop; pop_id = VECS[v].oid;
      inj = VECS[v].inj; inj_id = VECS[v].iid;
      lkp_id = VECS[v].lid;
      @(posedge clk); #5;
      check($sformatf("R%0d vector %0d", VECS[v].req, v),
            VECS[v].eport, VECS[v].ebusy, VECS[v].efull);
    end
    @(negedge clk); drive_idle();

    // R2: lookup follows lkp_id without a clock edge
    push = 1'b1; push_id = 2'd3; push_port = 2'd2;
    @(posedge clk); #5; drive_idle();
    lkp_id = 2'd3; #1;
    check("R2 lookup slot3", 2'd2, 1'b1, 1'b0);
    lkp_id = 2'd0; #1;
    check("R2 lookup slot0", 2'd0, 1'b0, 1'b0);
    lkp_id = 2'd1; #1;
    check("R2 lookup slot1 port kept", 2'd2, 1'b0, 1'b0);

    // R1: asynchronous reset clears a busy slot and its port
    @(negedge clk); rst_n = 1'b0; lkp_id = 2'd3; #2;
    check("R1 async reset slot3", 2'd0, 1'b0, 1'b0);
    lkp_id = 2'd1; #1;
    check("R1 async reset slot1", 2'd0, 1'b0, 1'b0);
    @(negedge clk); rst_n = 1'b1;

    // R7: fill slot0 to MAX, then one pop clears full
    for (int k = 0; k < 3; k++) begin
      @(negedge clk); push = 1'b1; push_id = 2'd0; push_port = 2'd1; lkp_id = 2'd0;
      @(posedge clk); #5;
      check($sformatf("R7 fill step %0d", k), 2'd1, 1'b1, (k == 2));
    end
    @(negedge clk); push = 1'b0; pop = 1'b1; pop_id = 2'd0;
    @(posedge clk); #5;
    check("R7 leave full", 2'd1, 1'b1, 1'b0);
    @(negedge clk); drive_idle();

    summary();
    $finish;
  end

  initial begin
    #200000;
    checks++; fails++;
    $display("FAIL watchdog: run hung, got timeout expected completion");
    summary();
    $finish;
  end
endmodule